// File: doc/BRIEF.md
# Multi-Port Fractional Bit-Rate Strobe Generator

This block derives a separate bit-rate strobe for each of several serial output lanes from one fast system clock. Every lane owns a phase accumulator that adds a programmable tuning word on every clock. The carry out of that addition is the lane's strobe. Because the rate comes from an accumulator and not from an integer divider, the rate can be set to a fraction of the clock with fine resolution. The cost is that a bit edge may fall up to one system clock later than the ideal instant.

Each strobe drives a small parallel-load serializer that presents one data bit per strobe period, most significant bit first. The tuning word of any lane may be rewritten while the lane runs. This changes only that lane, and the lane's phase carries on from where it was. Everything lives in one clock domain, so no clock-domain crossing exists. With a 100 MHz clock, a 1 Mbps lane uses the word 42949673 and a 15 Mbps lane uses 644245094, which is round(rate × 2^32 / f_clk).

Top module: `rate_strobe_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, every `ser_out` bit is 1, every `ready` bit is 1 and every `bit_en` bit is 0. Reset clears each lane's phase and tuning word.
- R2: Each lane keeps a 32-bit phase that grows by its tuning word modulo 2^32 on every clock. `bit_en` for the lane is high in exactly those cycles where phase + tuning word ≥ 2^32.
- R3: While the tuning word T of a lane stays constant, the spacing between consecutive strobes is floor(2^32/T) or that value plus one. Over 10 strobe periods at T = 42949673 the span is 1000 ± 1 clocks.
- R4: A write with `tw_wr_en` high stores `tw_wr_word` into the lane numbered by `tw_wr_sel`. The new word is used for the addition at the next clock edge after the write edge. The phase is not cleared, and other lanes are not touched.
- R5: A lane whose tuning word is 0 never raises `bit_en`, and its `ser_out` holds its current value.
- R6: `ser_out` of a lane changes only at the clock edge that ends a cycle where that lane's `bit_en` is high.
- R7: When `bit_en`, `ready` and `load_valid` of a lane are all high, the lane's byte in `load_data` (bits [8p+7:8p]) is taken. `ser_out` shows bit 7 from the next cycle on. Bits 6 down to 0 follow, one per strobe.
- R8: `ready` is high exactly when no bits of a byte remain after the one on the line, which includes the period of the last bit. `load_valid` has no effect while `ready` is low.
- R9: A strobe with `ready` high and `load_valid` low drives `ser_out` to 1 (idle) from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_wr_en | input | 1 | Tuning-word write strobe |
| tw_wr_sel | input | 2 | Lane number written |
| tw_wr_word | input | 32 | New tuning word |
| load_valid | input | 3 | Per-lane byte offered for loading |
| load_data | input | 24 | Per-lane bytes, lane p at [8p+7:8p] |
| ready | output | 3 | Lane serializer has no bits remaining |
| bit_en | output | 3 | Per-lane one-clock rate strobe |
| ser_out | output | 3 | Per-lane serial data line |

## Verification
`bit_en` follows from registered phase and tuning word through adders only, so it belongs to the same cycle as the state that produces it. A tuning-word write first affects the strobe in the cycle after the write edge. `ser_out` and `ready` move one edge after a strobe cycle. The bench drives inputs at the falling edge and advances its own model of phase and serializer once for each rising edge. At the next falling edge it compares all three outputs of every lane, so each result is checked in the cycle it is due.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  localparam int RSG_ACC_W_DEF  = 32;
  localparam int RSG_DATA_W_DEF = 8;

  // width needed to hold the value n
  function automatic int width_for(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/rsg_phase_acc.sv
module rsg_phase_acc #(
  parameter int ACC_W = rsg_pkg::RSG_ACC_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [ACC_W-1:0] wr_word,
  output logic             strobe,
  output logic             tw_zero
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] tw_q;
  logic [ACC_W-1:0] acc_sum;

  // phase step: returns {carry, wrapped sum}
  function automatic logic [ACC_W:0] phase_step(input logic [ACC_W-1:0] ph,
                                                input logic [ACC_W-1:0] inc);
    return {1'b0, ph} + {1'b0, inc};
  endfunction

  always_comb begin
    {strobe, acc_sum} = phase_step(acc_q, tw_q);
  end

  assign tw_zero = (tw_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tw_q  <= '0;
    end else begin
      acc_q <= acc_sum;
      if (wr) tw_q <= wr_word;
    end
  end

endmodule

// File: rtl/rsg_serializer.sv
module rsg_serializer #(
  parameter int DATA_W = rsg_pkg::RSG_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_word,
  output logic              ready,
  output logic              taken,
  output logic              line
);

  localparam int CNT_W = rsg_pkg::width_for(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  assign ready = (left_q == '0);
  assign taken = strobe && ready && load_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      line   <= 1'b1;
    end else if (strobe) begin
      if (!ready) begin
        line   <= sh_q[DATA_W-1];
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
      end else if (load_valid) begin
        line   <= load_word[DATA_W-1];
        sh_q   <= load_word << 1;
        left_q <= CNT_W'(DATA_W - 1);
      end else begin
        line   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen #(
  parameter int NPORTS = 3,
  parameter int ACC_W  = rsg_pkg::RSG_ACC_W_DEF,
  parameter int DATA_W = rsg_pkg::RSG_DATA_W_DEF,
  localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tw_wr_en,
  input  logic [SEL_W-1:0]         tw_wr_sel,
  input  logic [ACC_W-1:0]         tw_wr_word,
  input  logic [NPORTS-1:0]        load_valid,
  input  logic [NPORTS*DATA_W-1:0] load_data,
  output logic [NPORTS-1:0]        ready,
  output logic [NPORTS-1:0]        bit_en,
  output logic [NPORTS-1:0]        ser_out
);

  // internal events brought out for the checker
  logic [NPORTS-1:0] taken;
  logic [NPORTS-1:0] tw_zero;
  logic [NPORTS-1:0] load_msb;

  for (genvar p = 0; p < NPORTS; p++) begin : g_lane
    logic lane_wr;
    assign lane_wr     = tw_wr_en && (tw_wr_sel == SEL_W'(p));
    assign load_msb[p] = load_data[p*DATA_W + DATA_W - 1];

    rsg_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .wr      (lane_wr),
      .wr_word (tw_wr_word),
      .strobe  (bit_en[p]),
      .tw_zero (tw_zero[p])
    );

    rsg_serializer #(.DATA_W(DATA_W)) u_ser (
      .clk        (clk),
      .rst        (rst),
      .strobe     (bit_en[p]),
      .load_valid (load_valid[p]),
      .load_word  (load_data[p*DATA_W +: DATA_W]),
      .ready      (ready[p]),
      .taken      (taken[p]),
      .line       (ser_out[p])
    );
  end

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
  parameter int NPORTS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NPORTS-1:0] bit_en,
  input logic [NPORTS-1:0] ready,
  input logic [NPORTS-1:0] ser_out,
  input logic [NPORTS-1:0] load_valid,
  input logic [NPORTS-1:0] load_msb,
  input logic [NPORTS-1:0] taken,
  input logic [NPORTS-1:0] tw_zero
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ser_out == '1 && ready == '1 && bit_en == '0));

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R5
    zero_mute_chk: assert property (@(posedge clk) disable iff (rst)
      tw_zero[p] |-> !bit_en[p]);

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !bit_en[p] |=> $stable(ser_out[p]));

    // R7
    load_msb_chk: assert property (@(posedge clk) disable iff (rst)
      taken[p] |=> (ser_out[p] == $past(load_msb[p]) && !ready[p]));

    // R8
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ready[p]) |-> $past(taken[p]));

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_en[p] && ready[p] && !load_valid[p]) |=> ser_out[p]);
  end

endmodule

bind rate_strobe_gen rsg_checker #(.NPORTS(NPORTS)) u_rsg_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .ready      (ready),
  .ser_out    (ser_out),
  .load_valid (load_valid),
  .load_msb   (load_msb),
  .taken      (taken),
  .tw_zero    (tw_zero)
);

// File: tb/rate_strobe_gen_bench.sv
`timescale 1ns/1ps
module rate_strobe_gen_bench;

  localparam int NP = 3;
  localparam int AW = 32;
  localparam int DW = 8;
  localparam longint unsigned MOD = 64'h1_0000_0000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tw_wr_en = 1'b0;
  logic [1:0]      tw_wr_sel = '0;
  logic [AW-1:0]   tw_wr_word = '0;
  logic [NP-1:0]   load_valid = '0;
  logic [NP*DW-1:0] load_data = '0;
  logic [NP-1:0]   ready, bit_en, ser_out;

  rate_strobe_gen u_rate_strobe_gen (
    .clk(clk), .rst(rst), .tw_wr_en(tw_wr_en), .tw_wr_sel(tw_wr_sel),
    .tw_wr_word(tw_wr_word), .load_valid(load_valid), .load_data(load_data),
    .ready(ready), .bit_en(bit_en), .ser_out(ser_out)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of each lane
  longint unsigned ph[NP];
  longint unsigned twm[NP];
  logic [DW-1:0]   shm[NP];
  int              left_m[NP];
  logic            out_m[NP];
  int              cyc;
  int              last_st[NP];
  bit              span_ok[NP];
  int              st_cnt[NP];
  int              st_first0, st_eleventh0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_strobe(input int p);
    return ((ph[p] + twm[p]) >= MOD);
  endfunction

  task automatic compare();
    for (int p = 0; p < NP; p++) begin
      bit es;
      es = exp_strobe(p);
      chk(bit_en[p] == es, "R2", $sformatf("bit_en lane %0d cyc %0d", p, cyc), bit_en[p], es);
      chk(ser_out[p] == out_m[p], "R7", $sformatf("ser_out lane %0d cyc %0d", p, cyc), ser_out[p], out_m[p]);
      chk(ready[p] == (left_m[p] == 0), "R8", $sformatf("ready lane %0d cyc %0d", p, cyc), ready[p], left_m[p] == 0);
      if (es) begin
        if (span_ok[p] && last_st[p] >= 0) begin
          longint lo;
          int gap;
          lo  = MOD / twm[p];
          gap = cyc - last_st[p];
          chk(gap >= lo && gap <= lo + 1, "R3", $sformatf("strobe gap lane %0d", p), gap, lo);
        end
        last_st[p] = cyc;
        span_ok[p] = 1;
        st_cnt[p]++;
        if (p == 0 && st_cnt[0] == 1)  st_first0 = cyc;
        if (p == 0 && st_cnt[0] == 11) st_eleventh0 = cyc;
      end
    end
  endtask

  // drive at the falling edge, advance model for the coming rising edge, compare at next falling edge
  task automatic tick(input bit wr, input int sel, input logic [AW-1:0] word,
                      input logic [NP-1:0] lv, input logic [NP*DW-1:0] ld);
    tw_wr_en   = wr;
    tw_wr_sel  = 2'(sel);
    tw_wr_word = word;
    load_valid = lv;
    load_data  = ld;
    for (int p = 0; p < NP; p++) begin
      bit es;
      es = exp_strobe(p);
      ph[p] = (ph[p] + twm[p]) % MOD;
      if (es) begin
        if (left_m[p] != 0) begin
          out_m[p] = shm[p][DW-1];
          shm[p]   = shm[p] << 1;
          left_m[p]--;
        end else if (lv[p]) begin
          out_m[p]  = ld[p*DW + DW - 1];
          shm[p]    = ld[p*DW +: DW] << 1;
          left_m[p] = DW - 1;
        end else begin
          out_m[p] = 1'b1;
        end
      end
      if (wr && sel == p) begin
        twm[p]     = longint'(word);
        span_ok[p] = 0;
      end
    end
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic idle(input int n, input logic [NP-1:0] lv, input logic [NP*DW-1:0] ld);
    for (int i = 0; i < n; i++) tick(0, 0, '0, lv, ld);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    void'($urandom(32'd20911));
    for (int p = 0; p < NP; p++) begin
      ph[p] = 0; twm[p] = 0; shm[p] = '0; left_m[p] = 0; out_m[p] = 1'b1;
      last_st[p] = -1; span_ok[p] = 0; st_cnt[p] = 0;
    end
    cyc = 0;
    st_first0 = 0;
    st_eleventh0 = 0;

    // R1: state while reset is held
    repeat (3) @(negedge clk);
    chk(ser_out == '1, "R1", "ser_out in reset", ser_out, 7);
    chk(ready == '1, "R1", "ready in reset", ready, 7);
    chk(bit_en == '0, "R1", "bit_en in reset", bit_en, 0);
    rst = 1'b0;
    compare();

    // R4: program lanes one write at a time; lane 1 stays at zero (R5)
    tick(1, 0, 32'd42949673, '0, '0);
    tick(1, 2, 32'd644245094, '0, '0);
    for (int p = 0; p < NP; p++) st_cnt[p] = 0;
    for (int i = 0; i < 1100; i++)
      tick(0, 0, '0, 3'b111, {8'($urandom), 8'h3C, 8'hA5});
    chk(st_cnt[1] == 0, "R5", "strobes on zero-word lane", st_cnt[1], 0);
    chk(st_cnt[0] >= 11, "R3", "1 Mbps strobe count", st_cnt[0], 11);
    chk((st_eleventh0 - st_first0) >= 999 && (st_eleventh0 - st_first0) <= 1001,
        "R3", "span of 10 periods at 1 Mbps", st_eleventh0 - st_first0, 1000);

    // R4: retune lane 0 mid-run, phase continues
    tick(1, 0, 32'd429496730, '0, '0);
    idle(200, 3'b001, {16'h0, 8'h96});

    // R5: stop lane 1 in the middle of a byte holding a 0 bit
    tick(1, 1, 32'h8000_0000, '0, '0);
    idle(6, 3'b010, {8'h0, 8'h00, 8'h0});
    tick(1, 1, 32'd0, '0, '0);
    idle(60, 3'b010, {8'h0, 8'hFF, 8'h0});
    chk(ser_out[1] == 1'b0, "R5", "line held on stopped lane", ser_out[1], 0);

    // R9: lanes drain and go idle high with no loads
    tick(1, 1, 32'h4000_0000, '0, '0);
    idle(400, '0, '0);
    chk(ser_out == '1, "R9", "idle line after drain", ser_out, 7);

    // constrained random: retunes, zero words, maximum words, random loads
    for (int i = 0; i < 20000; i++) begin
      bit wr;
      int sel;
      logic [AW-1:0] w;
      int r;
      wr  = ($urandom % 48) == 0;
      sel = int'($urandom % NP);
      r   = int'($urandom % 10);
      if (r == 0)      w = '0;
      else if (r == 1) w = 32'hFFFF_FFFF;
      else             w = 32'(MOD / longint'(2 + ($urandom % 60)) + ($urandom % 1000));
      tick(wr, sel, w, 3'($urandom), 24'($urandom));
    end

    report();
  end

endmodule